// File: doc/BRIEF.md
# Embedded Interval and Watchdog Timer Unit

This unit gives an embedded core three timers behind one small register port. A down-counting interval timer counts a programmed number of timebase ticks and can reload itself. A fixed-period timer flags each rising transition of a chosen bit of the free-running time-base value. A watchdog escalates on its own chosen time-base bit. On the first expiry it arms itself. On the second it raises an interrupt. On the third it issues a reset request of a programmed kind.

Software programs a control word and reads a status word, which it clears by writing ones. It can also load the interval counter and read its current count back. The unit only reports the reset kind as a code. The reset actions themselves belong to the surrounding chip.

Top module: `emb_tmr_unit`

## Requirements
- R1: A control write (address 0) stores only data bits 31:22, which read back unchanged while bits 21:0 read zero. Field layout: watchdog period code 31:30, watchdog reset kind 29:28, watchdog interrupt enable 27, interval interrupt enable 26, fixed-period code 25:24, fixed-period interrupt enable 23, interval auto-reload 22.
- R2: The status word (address 1) holds watchdog armed 31, watchdog interrupt seen 30, latched reset kind 29:28, interval expired 27 and fixed-period elapsed 26, with bits 25:0 reading zero. A status write clears exactly those bits among 31:26 that are written as one.
- R3: A status write with bit 31 set drops `irq_pit`. Clearing bit 26 drops `irq_fit`. Clearing bit 30 drops `irq_wdt`.
- R4: A write to address 2 stores a reload value. If that value exceeds 1 and the interval interrupt enable is set, the count takes the value and falls by one per `tick`. Otherwise the counter stops and reads 0.
- R5: When the running count would pass from 1 to 0 on a `tick`, status bit 27 is set and `irq_pit` rises.
- R6: At that expiry the count takes the reload value again if auto-reload is set. If auto-reload is clear, the counter stops at 0.
- R7: A control write stops the interval counter (reading 0) unless the stored reload exceeds 1 and the new word has both the interval enable and auto-reload set. When allowed, a stopped counter starts from the reload value and a running counter keeps its count.
- R8: A 0-to-1 transition of time-base bit 9+4*code (fixed-period code 0..3) sets status bit 26, and raises `irq_fit` when its enable is set. Transitions of other bits have no effect.
- R9: A 0-to-1 transition of time-base bit 17+4*code (watchdog code 0..3) acts on status bits {31,30}. From 00 or 01 it sets bit 31. From 10 it sets bit 30 and raises `irq_wdt` when the watchdog interrupt enable is set.
- R10: The same transition with status bits {31,30} = 11 copies the reset-kind field into status bits 29:28. It also drives `rst_req` with that code (0 none, 1 core, 2 chip, 3 system) for exactly one cycle, and 0 otherwise.
- R11: After reset, all registers, the count and every output are zero.
- R12: Reads from address 2 return the current count, and address 3 reads zero. Writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase tick that decrements the interval counter |
| tb_val | input | TB_W | Free-running time-base value |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 interval count, 3 none |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| irq_pit | output | 1 | Interval timer interrupt line |
| irq_fit | output | 1 | Fixed-period interrupt line |
| irq_wdt | output | 1 | Watchdog interrupt line |
| rst_req | output | 2 | One-cycle reset request code |

## Verification
The assertions watch invariants on every cycle. The count never exceeds its reload value, and a running counter is never at zero. An expiry always leaves the count at the reload value or at zero. A reset request lasts one cycle and agrees with the latched status field. The interrupt-seen bit only rises after the armed bit, and each interrupt line only rises with its status bit set. Only the bench's scenarios can show the exact tick on which the interval timer expires and the choice of time-base bit for each period code. The same holds for the separate clear paths of the interrupt lines and the full three-step watchdog walk, including the 01 state reached by clearing only the armed bit.

// File: rtl/emb_tmr_pkg.sv
package emb_tmr_pkg;

   localparam int WORD_W   = 32;
   localparam int CTRL_LSB = 22;
   localparam int STAT_LSB = 26;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_STAT = 2'd1,
      SEL_PIT  = 2'd2,
      SEL_VOID = 2'd3
   } tmr_sel_e;

   // Control word, bits 31:22 in this order
   typedef struct packed {
      logic [1:0] wd_per;
      logic [1:0] wd_rst;
      logic       wd_ie;
      logic       pit_ie;
      logic [1:0] fit_per;
      logic       fit_ie;
      logic       pit_auto;
   } tmr_ctrl_t;

   // Status word, bits 31:26 in this order
   typedef struct packed {
      logic       wd_arm;
      logic       wd_hit;
      logic [1:0] wd_rst;
      logic       pit_st;
      logic       fit_st;
   } tmr_stat_t;

endpackage

// File: rtl/tmr_tb_edge.sv
module tmr_tb_edge #(
   parameter int TB_W = 64,
   parameter int BIT0 = 9,
   parameter int STEP = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [TB_W-1:0] tb_val,
   input  logic [1:0]      sel,
   output logic            hit
);
   localparam int NSEL = 4;

   generate
      if (BIT0 < 0 || STEP < 1 || BIT0 + (NSEL-1)*STEP >= TB_W) begin : g_bad
         $error("tmr_tb_edge: selectable bits exceed the time-base width");
      end
   endgenerate

   logic [NSEL-1:0] cur, prev;
   logic            unused_tb;
   assign unused_tb = ^tb_val;

   generate
      for (genvar g = 0; g < NSEL; g++) begin : g_tap
         assign cur[g] = tb_val[BIT0 + g*STEP];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= cur;
   end

   assign hit = cur[sel] & ~prev[sel];

   // R8/R9: one rising transition yields one event while the selection holds
   a_r8_hit_single: assert property (@(posedge clk) disable iff (!rst_n)
      (hit ##1 $stable(sel)) |-> !hit);

endmodule

// File: rtl/tmr_pit_core.sv
module tmr_pit_core #(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          ld_we,
   input  logic [CW-1:0] ld_val,
   input  logic          ctl_we,
   input  logic          ie,
   input  logic          auto_on,
   input  logic          ie_next,
   input  logic          auto_next,
   output logic [CW-1:0] cnt,
   output logic          expire
);
   generate
      if (CW < 2 || CW > 32) begin : g_bad
         $error("tmr_pit_core: counter width must lie in 2..32");
      end
   endgenerate

   localparam logic [CW-1:0] ONE = CW'(1);

   logic [CW-1:0] reload_q;
   logic          run_q;
   logic          go_ld, go_ctl, go_again;

   assign go_ld    = (ld_val > ONE) && ie;
   assign go_ctl   = (reload_q > ONE) && ie_next && auto_next;
   assign go_again = (reload_q > ONE) && ie && auto_on;
   assign expire   = run_q && tick && (cnt == ONE) && !ld_we && !ctl_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '0;
         cnt      <= '0;
         run_q    <= 1'b0;
      end else if (ld_we) begin
         reload_q <= ld_val;
         run_q    <= go_ld;
         cnt      <= go_ld ? ld_val : '0;
      end else if (ctl_we) begin
         if (!go_ctl) begin
            run_q <= 1'b0;
            cnt   <= '0;
         end else if (!run_q) begin
            run_q <= 1'b1;
            cnt   <= reload_q;
         end
      end else if (run_q && tick) begin
         if (cnt == ONE) begin
            run_q <= go_again;
            cnt   <= go_again ? reload_q : '0;
         end else begin
            cnt <= cnt - ONE;
         end
      end
   end

   // R4: the count stays within the stored reload value
   a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= reload_q);
   // R4: running and a non-zero count go together
   a_r4_run_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      run_q == (cnt != '0));
   // R6: an expiry leaves either the reload value or a stopped counter
   a_r6_after_expire: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (cnt == $past(reload_q)) || (cnt == '0));

endmodule

// File: rtl/tmr_wdt_stage.sv
module tmr_wdt_stage (
   input  logic hit,
   input  logic arm,
   input  logic seen,
   output logic set_arm,
   output logic set_seen,
   output logic fire
);
   always_comb begin
      set_arm  = 1'b0;
      set_seen = 1'b0;
      fire     = 1'b0;
      if (hit) begin
         unique case ({arm, seen})
            2'b00, 2'b01: set_arm  = 1'b1;
            2'b10:        set_seen = 1'b1;
            default:      fire     = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/emb_tmr_unit.sv
module emb_tmr_unit #(
   parameter int TB_W     = 64,
   parameter int PIT_W    = 32,
   parameter int FIT_BIT0 = 9,
   parameter int WDT_BIT0 = 17,
   parameter int PER_STEP = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic [TB_W-1:0] tb_val,
   input  logic            reg_we,
   input  logic [1:0]      reg_addr,
   input  logic [31:0]     reg_wdata,
   output logic [31:0]     reg_rdata,
   output logic            irq_pit,
   output logic            irq_fit,
   output logic            irq_wdt,
   output logic [1:0]      rst_req
);
   import emb_tmr_pkg::*;

   localparam int CTRL_W = $bits(tmr_ctrl_t);
   localparam int STAT_W = $bits(tmr_stat_t);

   generate
      if (CTRL_LSB + CTRL_W != WORD_W || STAT_LSB + STAT_W != WORD_W) begin : g_bad
         $error("emb_tmr_unit: register fields do not fill the top of the word");
      end
   endgenerate

   tmr_sel_e        sel;
   logic            wr_ctl, wr_stat, wr_pit;
   tmr_ctrl_t       ctrl_q, ctrl_new;
   tmr_stat_t       stat_q, stat_nx;
   logic [STAT_W-1:0] clr;
   logic [PIT_W-1:0]  pit_cnt;
   logic            pit_exp, fit_hit, wd_tick;
   logic            set_arm, set_seen, fire;

   assign sel      = tmr_sel_e'(reg_addr);
   assign wr_ctl   = reg_we && (sel == SEL_CTRL);
   assign wr_stat  = reg_we && (sel == SEL_STAT);
   assign wr_pit   = reg_we && (sel == SEL_PIT);
   assign ctrl_new = tmr_ctrl_t'(reg_wdata[WORD_W-1:CTRL_LSB]);
   assign clr      = wr_stat ? reg_wdata[WORD_W-1:STAT_LSB] : '0;

   tmr_pit_core #(.CW(PIT_W)) u_pit (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .ld_we     (wr_pit),
      .ld_val    (reg_wdata[PIT_W-1:0]),
      .ctl_we    (wr_ctl),
      .ie        (ctrl_q.pit_ie),
      .auto_on   (ctrl_q.pit_auto),
      .ie_next   (ctrl_new.pit_ie),
      .auto_next (ctrl_new.pit_auto),
      .cnt       (pit_cnt),
      .expire    (pit_exp)
   );

   tmr_tb_edge #(.TB_W(TB_W), .BIT0(FIT_BIT0), .STEP(PER_STEP)) u_fit_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .tb_val (tb_val),
      .sel    (ctrl_q.fit_per),
      .hit    (fit_hit)
   );

   tmr_tb_edge #(.TB_W(TB_W), .BIT0(WDT_BIT0), .STEP(PER_STEP)) u_wdt_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .tb_val (tb_val),
      .sel    (ctrl_q.wd_per),
      .hit    (wd_tick)
   );

   tmr_wdt_stage u_wdt (
      .hit      (wd_tick),
      .arm      (stat_q.wd_arm),
      .seen     (stat_q.wd_hit),
      .set_arm  (set_arm),
      .set_seen (set_seen),
      .fire     (fire)
   );

   always_comb begin
      stat_nx = tmr_stat_t'(STAT_W'(stat_q) & ~clr);
      if (pit_exp)  stat_nx.pit_st = 1'b1;
      if (fit_hit)  stat_nx.fit_st = 1'b1;
      if (set_arm)  stat_nx.wd_arm = 1'b1;
      if (set_seen) stat_nx.wd_hit = 1'b1;
      if (fire)     stat_nx.wd_rst = ctrl_q.wd_rst;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         stat_q  <= '0;
         irq_pit <= 1'b0;
         irq_fit <= 1'b0;
         irq_wdt <= 1'b0;
         rst_req <= 2'd0;
      end else begin
         if (wr_ctl) ctrl_q <= ctrl_new;
         stat_q <= stat_nx;
         if (pit_exp && ctrl_q.pit_ie)        irq_pit <= 1'b1;
         else if (wr_stat && reg_wdata[31])   irq_pit <= 1'b0;
         if (fit_hit && ctrl_q.fit_ie)        irq_fit <= 1'b1;
         else if (clr[0])                     irq_fit <= 1'b0;
         if (set_seen && ctrl_q.wd_ie)        irq_wdt <= 1'b1;
         else if (clr[4])                     irq_wdt <= 1'b0;
         rst_req <= fire ? ctrl_q.wd_rst : 2'd0;
      end
   end

   always_comb begin
      unique case (sel)
         SEL_CTRL: reg_rdata = {ctrl_q, {CTRL_LSB{1'b0}}};
         SEL_STAT: reg_rdata = {stat_q, {STAT_LSB{1'b0}}};
         SEL_PIT:  reg_rdata = 32'(pit_cnt);
         default:  reg_rdata = '0;
      endcase
   end

   // R10: a reset request lasts a single cycle
   a_r10_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req != 2'd0) |=> (rst_req == 2'd0));
   // R10: a request agrees with the latched kind and both watchdog bits
   a_r10_rst_status: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req != 2'd0) |-> (stat_q.wd_arm && stat_q.wd_hit && stat_q.wd_rst == rst_req));
   // R9: the interrupt-seen bit only rises once the watchdog was armed
   a_r9_seen_after_arm: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q.wd_hit) |-> $past(stat_q.wd_arm));
   // R5: the interval interrupt only rises with its status bit
   a_r5_pit_irq_status: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_pit) |-> stat_q.pit_st);
   // R8: the fixed-period interrupt only rises with its status bit
   a_r8_fit_irq_status: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_fit) |-> stat_q.fit_st);
   // R9: the watchdog interrupt only rises with the seen bit
   a_r9_wdt_irq_status: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_wdt) |-> stat_q.wd_hit);

endmodule

// File: tb/test_emb_tmr_unit.sv
module test_emb_tmr_unit;

   localparam int CLK_PERIOD = 10;
   localparam int TB_W       = 64;
   localparam int WATCH_CYC  = 20000;

   localparam logic [2:0] K_WR  = 3'd0;  // write addr/data
   localparam logic [2:0] K_RD  = 3'd1;  // read addr, compare with exp
   localparam logic [2:0] K_TK  = 3'd2;  // data ticks
   localparam logic [2:0] K_TB  = 3'd3;  // time base := data, one clock
   localparam logic [2:0] K_OUT = 3'd4;  // {pit,fit,wdt,rst[1:0]} vs exp

   localparam int NV = 61;
   // {kind, addr, req, data, exp}
   localparam logic [72:0] VEC [NV] = '{
      {K_RD,  2'd0, 4'd11, 32'h0,        32'h0},        // R11
      {K_RD,  2'd1, 4'd11, 32'h0,        32'h0},
      {K_RD,  2'd2, 4'd11, 32'h0,        32'h0},
      {K_OUT, 2'd0, 4'd11, 32'h0,        32'h0},
      {K_WR,  2'd0, 4'd1,  32'hFFFFFFFF, 32'h0},        // R1
      {K_RD,  2'd0, 4'd1,  32'h0,        32'hFFC00000},
      {K_WR,  2'd0, 4'd1,  32'h04400000, 32'h0},
      {K_RD,  2'd0, 4'd1,  32'h0,        32'h04400000},
      {K_WR,  2'd2, 4'd4,  32'd5,        32'h0},        // R4
      {K_RD,  2'd2, 4'd4,  32'h0,        32'd5},
      {K_TK,  2'd0, 4'd4,  32'd2,        32'h0},
      {K_RD,  2'd2, 4'd4,  32'h0,        32'd3},
      {K_TK,  2'd0, 4'd6,  32'd3,        32'h0},        // R6 reload
      {K_RD,  2'd2, 4'd6,  32'h0,        32'd5},
      {K_RD,  2'd1, 4'd5,  32'h0,        32'h08000000}, // R5
      {K_OUT, 2'd0, 4'd5,  32'h0,        32'h10},
      {K_WR,  2'd1, 4'd3,  32'h80000000, 32'h0},        // R3
      {K_RD,  2'd1, 4'd2,  32'h0,        32'h08000000}, // R2
      {K_OUT, 2'd0, 4'd3,  32'h0,        32'h00},
      {K_WR,  2'd1, 4'd2,  32'h08000000, 32'h0},
      {K_RD,  2'd1, 4'd2,  32'h0,        32'h0},
      {K_WR,  2'd0, 4'd7,  32'h04000000, 32'h0},        // R7 stop
      {K_RD,  2'd2, 4'd7,  32'h0,        32'h0},
      {K_WR,  2'd2, 4'd4,  32'd3,        32'h0},
      {K_RD,  2'd2, 4'd4,  32'h0,        32'd3},
      {K_TK,  2'd0, 4'd6,  32'd3,        32'h0},        // R6 no reload
      {K_RD,  2'd2, 4'd6,  32'h0,        32'h0},
      {K_RD,  2'd1, 4'd5,  32'h0,        32'h08000000},
      {K_OUT, 2'd0, 4'd5,  32'h0,        32'h10},
      {K_WR,  2'd1, 4'd2,  32'h88000000, 32'h0},
      {K_RD,  2'd1, 4'd2,  32'h0,        32'h0},
      {K_OUT, 2'd0, 4'd3,  32'h0,        32'h00},
      {K_WR,  2'd0, 4'd7,  32'h04400000, 32'h0},        // R7 start
      {K_RD,  2'd2, 4'd7,  32'h0,        32'd3},
      {K_TK,  2'd0, 4'd7,  32'd1,        32'h0},
      {K_RD,  2'd2, 4'd7,  32'h0,        32'd2},
      {K_WR,  2'd0, 4'd7,  32'h04400000, 32'h0},        // R7 keep
      {K_RD,  2'd2, 4'd7,  32'h0,        32'd2},
      {K_WR,  2'd0, 4'd7,  32'h00400000, 32'h0},
      {K_RD,  2'd2, 4'd7,  32'h0,        32'h0},
      {K_WR,  2'd0, 4'd4,  32'h04400000, 32'h0},
      {K_WR,  2'd2, 4'd4,  32'd1,        32'h0},        // R4 reload 1
      {K_RD,  2'd2, 4'd4,  32'h0,        32'h0},
      {K_WR,  2'd3, 4'd12, 32'hFFFFFFFF, 32'h0},        // R12
      {K_RD,  2'd3, 4'd12, 32'h0,        32'h0},
      {K_RD,  2'd0, 4'd12, 32'h0,        32'h04400000},
      {K_WR,  2'd0, 4'd8,  32'h01800000, 32'h0},        // R8
      {K_TB,  2'd0, 4'd8,  32'h00002000, 32'h0},
      {K_RD,  2'd1, 4'd8,  32'h0,        32'h04000000},
      {K_OUT, 2'd0, 4'd8,  32'h0,        32'h08},
      {K_TB,  2'd0, 4'd8,  32'h00000200, 32'h0},
      {K_RD,  2'd1, 4'd8,  32'h0,        32'h04000000},
      {K_WR,  2'd1, 4'd3,  32'h04000000, 32'h0},
      {K_RD,  2'd1, 4'd3,  32'h0,        32'h0},
      {K_OUT, 2'd0, 4'd3,  32'h0,        32'h00},
      {K_WR,  2'd0, 4'd8,  32'h01000000, 32'h0},
      {K_TB,  2'd0, 4'd8,  32'h0,        32'h0},
      {K_TB,  2'd0, 4'd8,  32'h00002000, 32'h0},
      {K_RD,  2'd1, 4'd8,  32'h0,        32'h04000000},
      {K_OUT, 2'd0, 4'd8,  32'h0,        32'h00},
      {K_WR,  2'd1, 4'd2,  32'hFC000000, 32'h0}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            tick = 1'b0;
   logic [TB_W-1:0] tb_val = '0;
   logic            reg_we = 1'b0;
   logic [1:0]      reg_addr = 2'd0;
   logic [31:0]     reg_wdata = '0;
   logic [31:0]     reg_rdata;
   logic            irq_pit, irq_fit, irq_wdt;
   logic [1:0]      rst_req;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   emb_tmr_unit i_emb_tmr_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .tb_val    (tb_val),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq_pit   (irq_pit),
      .irq_fit   (irq_fit),
      .irq_wdt   (irq_wdt),
      .rst_req   (rst_req)
   );

   task automatic op_wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic op_tick(input int n);
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic op_tb(input logic [31:0] v);
      @(negedge clk);
      tb_val = TB_W'(v);
      @(negedge clk);
   endtask

   task automatic chk_rd(input logic [1:0] a, input logic [31:0] e, input string tag);
      reg_addr = a;
      #1;
      n_chk++;
      if (reg_rdata !== e) begin
         n_bad++;
         $display("FAIL %s read addr %0d: got %08h expected %08h", tag, a, reg_rdata, e);
      end
   endtask

   task automatic chk_out(input logic [4:0] e, input string tag);
      logic [4:0] got;
      #1;
      got = {irq_pit, irq_fit, irq_wdt, rst_req};
      n_chk++;
      if (got !== e) begin
         n_bad++;
         $display("FAIL %s outputs {pit,fit,wdt,rst}: got %05b expected %05b", tag, got, e);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (WATCH_CYC) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [2:0]  k;
         logic [1:0]  a;
         logic [3:0]  rq;
         logic [31:0] d, e;
         {k, a, rq, d, e} = VEC[i];
         case (k)
            K_WR:    op_wr(a, d);
            K_RD:    chk_rd(a, e, $sformatf("R%0d", rq));
            K_TK:    op_tick(int'(d));
            K_TB:    op_tb(d);
            default: chk_out(e[4:0], $sformatf("R%0d", rq));
         endcase
      end

      // R9 / R10: watchdog on code 0 (bit 17), chip reset kind, interrupt on
      op_tb(32'h0);
      op_wr(2'd0, 32'h28000000);
      op_tb(32'h00020000);
      chk_rd(2'd1, 32'h80000000, "R9");
      chk_out(5'b00000, "R9");
      op_tb(32'h0);
      op_tb(32'h00020000);
      chk_rd(2'd1, 32'hC0000000, "R9");
      chk_out(5'b00100, "R9");
      op_tb(32'h0);
      op_tb(32'h00020000);
      chk_rd(2'd1, 32'hE0000000, "R10");
      chk_out(5'b00110, "R10");
      op_tb(32'h00020000);
      chk_out(5'b00100, "R10");
      op_wr(2'd1, 32'hFC000000);
      chk_rd(2'd1, 32'h0, "R3");
      chk_out(5'b00000, "R3");

      // R9: code 3 (bit 29), state 01 reached by clearing only bit 31
      op_tb(32'h0);
      op_wr(2'd0, 32'hC0000000);
      op_tb(32'h20000000);
      chk_rd(2'd1, 32'h80000000, "R9");
      op_tb(32'h0);
      op_tb(32'h20000000);
      chk_rd(2'd1, 32'hC0000000, "R9");
      chk_out(5'b00000, "R9");
      op_wr(2'd1, 32'h80000000);
      chk_rd(2'd1, 32'h40000000, "R9");
      op_tb(32'h0);
      op_tb(32'h20000000);
      chk_rd(2'd1, 32'hC0000000, "R9");
      // R10: kind 0 latches 00 and requests nothing
      op_tb(32'h0);
      op_tb(32'h20000000);
      chk_out(5'b00000, "R10");
      chk_rd(2'd1, 32'hC0000000, "R10");
      op_wr(2'd1, 32'hFC000000);
      op_tb(32'h0);

      // R6: several auto-reload periods in a row
      op_wr(2'd0, 32'h04400000);
      op_wr(2'd2, 32'd4);
      op_tick(12);
      chk_rd(2'd2, 32'd4, "R6");
      chk_rd(2'd1, 32'h08000000, "R5");
      op_tick(1);
      chk_rd(2'd2, 32'd3, "R6");

      // R11: reset in the middle of activity
      op_wr(2'd0, 32'hFFC00000);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk_rd(2'd0, 32'h0, "R11");
      chk_rd(2'd1, 32'h0, "R11");
      chk_rd(2'd2, 32'h0, "R11");
      chk_out(5'b00000, "R11");
      rst_n = 1'b1;
      @(negedge clk);

      finish_run();
   end

endmodule